// File: doc/BRIEF.md
# PTP Timestamp Capture Register Bank

This block keeps a free-running seconds and nanoseconds time counter and four capture records. Each record holds the counter value taken at the start of a precision-time frame. The four records are selected by two qualifiers that arrive with the capture strobe: the direction (receive or transmit) and the message class (ordinary event or peer-delay). The frame parser outside the block decides whether a frame is a timing event at all. It presents that decision as a qualifier, and a strobe without it is dropped.

Software reaches the counter, the records, a sticky per-record status word and an interrupt mask through an APB slave port with zero wait states. Each record has a status bit that is set on capture and cleared by writing one. An overrun bit marks a record that was overwritten before its status was cleared. The interrupt output combines the status bits with the mask. Reading any nanoseconds word latches the matching seconds value into a shadow register, so the 78 live bits of a time value read out as one consistent sample. The counter can be loaded from software.

Top module: `ptp_ts_bank`

## Requirements
- R1: After reset, all records, the counter, the staged load seconds, the shadow, the status, overrun and mask bits are zero, and irq_o is low.
- R2: On every clock, the counter's nanoseconds value (30 bits) grows by NS_INC (default 8). When the sum reaches 1,000,000,000 it wraps to the sum minus 1,000,000,000 and the 48-bit seconds value increments, with the carry passing from bit 31 into bit 32.
- R3: A write to byte 0x04 stages seconds[31:0], and a write to 0x08 stages seconds[47:32] from bits 15:0. A write to 0x00 loads nanoseconds from bits 29:0, together with the staged seconds, into the counter, and the counter holds that value after the write edge. A read of 0x00 returns the counter's current nanoseconds.
- R4: When cap_valid_i and cap_ptp_i are both high at a clock edge, record k = {cap_peer_i, cap_dir_i} takes the counter value held before that edge. The records are 0 event receive, 1 event transmit, 2 peer receive and 3 peer transmit. The other records keep their values.
- R5: A strobe on cap_valid_i with cap_ptp_i low changes no record, no status bit, no overrun bit and leaves irq_o unchanged.
- R6: Record k is read at byte 0x20+0x10*k. Offset +0 is nanoseconds in bits 29:0 with bits 31:30 zero, +4 is seconds[31:0], and +8 is seconds[47:32] in bits 15:0 with the upper bits zero.
- R7: A read of a nanoseconds word (the counter at 0x00 or a record at +0) latches that source's seconds into one shared shadow. Reads of the seconds words (0x04, 0x08, record +4 and +8) return the shadow, whatever has changed since.
- R8: Status bit k at byte 0x0C (bits 3:0) is set on the edge that captures into record k and stays set until a write with bit k at one. Writing zero leaves it. A capture on the same edge as a clear leaves it set.
- R9: A capture into record k while status bit k is set overwrites the record and sets overrun bit 4+k of 0x0C. That bit is cleared by writing one to it.
- R10: irq_o is high exactly when some status bit k is set and mask bit k (byte 0x10, bits 3:0, read/write) is set.
- R11: pready_o is always high. Reads of unmapped words, including record offset +0xC, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_valid_i | input | 1 | Start-of-frame capture strobe, one cycle |
| cap_ptp_i | input | 1 | Frame is a timing event; gates the capture |
| cap_peer_i | input | 1 | 1 = peer-delay message, 0 = ordinary event |
| cap_dir_i | input | 1 | 1 = transmit, 0 = receive |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| irq_o | output | 1 | Masked record-update interrupt |

## Verification
The nanoseconds range assertion takes for granted that software only ever loads a nanoseconds value below one billion. The bench loads only legal values. The capture assertions take for granted that a strobe lasts one clock and carries its qualifiers on that same clock, which the capture task drives. Expected timestamps come from loading the counter immediately before a strobe and counting the clocks between the load edge and the capture edge, so every expected record value is fixed by the stimulus schedule alone.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
  localparam int unsigned SEC_W   = 48;
  localparam int unsigned NS_W    = 30;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_REC = 4;
  localparam int unsigned REC_IDX_W = $clog2(NUM_REC);
  localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1_000_000_000);

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } ts_t;

  // word field within a 16-byte region
  typedef enum logic [1:0] {
    FLD_NS     = 2'd0,
    FLD_SEC_LO = 2'd1,
    FLD_SEC_HI = 2'd2,
    FLD_AUX    = 2'd3
  } fld_e;
endpackage

// File: rtl/ptp_ts_timer.sv
module ptp_ts_timer
  import ptp_ts_pkg::*;
#(
  parameter int unsigned NS_INC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  ts_t  load_val_i,
  output ts_t  now_o
);
  logic [NS_W-1:0]  ns_q, ns_nxt;
  logic [SEC_W-1:0] sec_q, sec_nxt;
  logic [NS_W:0]    ns_sum;

  always_comb begin
    ns_sum  = {1'b0, ns_q} + (NS_W+1)'(NS_INC);
    ns_nxt  = ns_sum[NS_W-1:0];
    sec_nxt = sec_q;
    if (ns_sum >= {1'b0, NS_PER_SEC}) begin
      ns_nxt  = NS_W'(ns_sum - {1'b0, NS_PER_SEC});
      sec_nxt = sec_q + SEC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else if (load_i) begin
      ns_q  <= load_val_i.ns;
      sec_q <= load_val_i.sec;
    end else begin
      ns_q  <= ns_nxt;
      sec_q <= sec_nxt;
    end
  end

  assign now_o = '{sec: sec_q, ns: ns_q};

  // R2
  ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_q < NS_PER_SEC);
  // R2
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + SEC_W'(1)));
  // R2
  ns_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && sec_nxt != sec_q) |=> ns_q < NS_W'(NS_INC));
endmodule

// File: rtl/ptp_ts_record.sv
module ptp_ts_record
  import ptp_ts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  ts_t  now_i,
  input  logic clr_sts_i,
  input  logic clr_ovr_i,
  output ts_t  rec_o,
  output logic sts_o,
  output logic ovr_o
);
  ts_t  rec_q;
  logic sts_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      sts_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (cap_i) rec_q <= now_i;
      // capture beats a same-cycle clear
      if (cap_i)          sts_q <= 1'b1;
      else if (clr_sts_i) sts_q <= 1'b0;
      if (cap_i && sts_q) ovr_q <= 1'b1;
      else if (clr_ovr_i) ovr_q <= 1'b0;
    end
  end

  assign rec_o = rec_q;
  assign sts_o = sts_q;
  assign ovr_o = ovr_q;

  // R4
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rec_q));
  // R4
  rec_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> rec_q == $past(now_i));
  // R8
  sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> sts_q);
  // R5
  sts_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> !$rose(sts_q) && !$rose(ovr_q));
  // R9
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && sts_q) |=> ovr_q);
endmodule

// File: rtl/ptp_ts_regs.sv
module ptp_ts_regs
  import ptp_ts_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned REC_BASE = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     psel_i,
  input  logic                     penable_i,
  input  logic                     pwrite_i,
  input  logic [ADDR_W-1:0]        paddr_i,
  input  logic [WORD_W-1:0]        pwdata_i,
  output logic [WORD_W-1:0]        prdata_o,
  input  ts_t                      now_i,
  output logic                     load_o,
  output ts_t                      load_val_o,
  input  ts_t [NUM_REC-1:0]        rec_i,
  input  logic [NUM_REC-1:0]       sts_i,
  input  logic [NUM_REC-1:0]       ovr_i,
  output logic [NUM_REC-1:0]       clr_sts_o,
  output logic [NUM_REC-1:0]       clr_ovr_o,
  output logic                     irq_o
);
  localparam int unsigned RG_W   = ADDR_W - 4;
  localparam int unsigned SEC_HI = SEC_W - WORD_W;

  logic [RG_W-1:0]      region, rec_off;
  fld_e                 field;
  logic                 in_tmr, in_msk, in_rec;
  logic [REC_IDX_W-1:0] rec_idx;
  logic                 wr, rd, ns_rd;
  ts_t                  src_ts;
  logic [SEC_W-1:0]     shadow_q, stage_q;
  logic [NUM_REC-1:0]   mask_q;

  assign region  = paddr_i[ADDR_W-1:4];
  assign field   = fld_e'(paddr_i[3:2]);
  assign rec_off = region - RG_W'(REC_BASE);
  assign rec_idx = rec_off[REC_IDX_W-1:0];
  assign in_tmr  = (region == RG_W'(0));
  assign in_msk  = (region == RG_W'(1));
  assign in_rec  = (region >= RG_W'(REC_BASE)) && (region < RG_W'(REC_BASE + NUM_REC));

  assign wr    = psel_i && penable_i &&  pwrite_i;
  assign rd    = psel_i && penable_i && !pwrite_i;
  assign ns_rd = rd && (in_tmr || in_rec) && (field == FLD_NS);

  assign src_ts = in_tmr ? now_i : rec_i[rec_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      stage_q  <= '0;
      mask_q   <= '0;
    end else begin
      if (ns_rd) shadow_q <= src_ts.sec;
      if (wr && in_tmr && field == FLD_SEC_LO) stage_q[WORD_W-1:0] <= pwdata_i;
      if (wr && in_tmr && field == FLD_SEC_HI) stage_q[SEC_W-1:WORD_W] <= pwdata_i[SEC_HI-1:0];
      if (wr && in_msk && field == FLD_NS) mask_q <= pwdata_i[NUM_REC-1:0];
    end
  end

  assign load_o     = wr && in_tmr && (field == FLD_NS);
  assign load_val_o = '{sec: stage_q, ns: pwdata_i[NS_W-1:0]};
  assign clr_sts_o  = (wr && in_tmr && field == FLD_AUX) ? pwdata_i[NUM_REC-1:0] : '0;
  assign clr_ovr_o  = (wr && in_tmr && field == FLD_AUX) ? pwdata_i[2*NUM_REC-1:NUM_REC] : '0;

  always_comb begin
    prdata_o = '0;
    if (in_tmr || in_rec) begin
      unique case (field)
        FLD_NS:     prdata_o = WORD_W'(src_ts.ns);
        FLD_SEC_LO: prdata_o = shadow_q[WORD_W-1:0];
        FLD_SEC_HI: prdata_o = WORD_W'(shadow_q[SEC_W-1:WORD_W]);
        FLD_AUX:    if (in_tmr) prdata_o = WORD_W'({ovr_i, sts_i});
        default:    prdata_o = '0;
      endcase
    end else if (in_msk && field == FLD_NS) begin
      prdata_o = WORD_W'(mask_q);
    end
  end

  assign irq_o = |(sts_i & mask_q);

  // R7
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ns_rd |=> $stable(shadow_q));
  // R3
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(stage_q) && $stable(mask_q));
endmodule

// File: rtl/ptp_ts_bank.sv
module ptp_ts_bank
  import ptp_ts_pkg::*;
#(
  parameter int unsigned NS_INC = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_valid_i,
  input  logic              cap_ptp_i,
  input  logic              cap_peer_i,
  input  logic              cap_dir_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              irq_o
);
  ts_t                      now, load_val;
  logic                     load;
  ts_t [NUM_REC-1:0]        rec;
  logic [NUM_REC-1:0]       sts, ovr, clr_sts, clr_ovr, cap_vec;
  logic                     cap_hit;
  logic [REC_IDX_W-1:0]     cap_idx;

  assign cap_hit  = cap_valid_i && cap_ptp_i;
  assign cap_idx  = {cap_peer_i, cap_dir_i};
  assign pready_o = 1'b1;

  ptp_ts_timer #(.NS_INC(NS_INC)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .now_o      (now)
  );

  for (genvar k = 0; k < NUM_REC; k++) begin : g_rec
    assign cap_vec[k] = cap_hit && (cap_idx == REC_IDX_W'(k));
    ptp_ts_record rec_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_i     (cap_vec[k]),
      .now_i     (now),
      .clr_sts_i (clr_sts[k]),
      .clr_ovr_i (clr_ovr[k]),
      .rec_o     (rec[k]),
      .sts_o     (sts[k]),
      .ovr_o     (ovr[k])
    );
  end

  ptp_ts_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .paddr_i    (paddr_i),
    .pwdata_i   (pwdata_i),
    .prdata_o   (prdata_o),
    .now_i      (now),
    .load_o     (load),
    .load_val_o (load_val),
    .rec_i      (rec),
    .sts_i      (sts),
    .ovr_i      (ovr),
    .clr_sts_o  (clr_sts),
    .clr_ovr_o  (clr_ovr),
    .irq_o      (irq_o)
  );

  // R5
  no_cap_unqualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid_i && !cap_ptp_i) |=> $stable(rec));
  // R10
  irq_after_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hit && !load && irq_o) |=> irq_o);
endmodule

// File: tb/ptp_ts_bank_tb_top.sv
module ptp_ts_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 0, cap_ptp = 0, cap_peer = 0, cap_dir = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ptp_ts_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cap_valid_i(cap_valid), .cap_ptp_i(cap_ptp), .cap_peer_i(cap_peer), .cap_dir_i(cap_dir),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data during each read access phase
  always @(negedge clk) begin
    #1;
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard-empty", prdata, 32'hx);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, prdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    exp_q.push_back(e); tag_q.push_back(r);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic cap(input logic peer, input logic dir, input logic ptp);
    cap_valid = 1; cap_peer = peer; cap_dir = dir; cap_ptp = ptp;
    @(negedge clk); cap_valid = 0; cap_ptp = 0;
  endtask

  task automatic load(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] ns);
    wr(8'h04, lo); wr(8'h08, hi); wr(8'h00, ns);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R11 pready", {31'd0, pready}, 32'd1);
    rd(8'h0C, 32'h0, "R1 status");
    rd(8'h10, 32'h0, "R1 mask");
    rd(8'h50, 32'h0, "R1 rec3 ns");
    rd(8'h24, 32'h0, "R1 shadow");

    // R3 load and readback, R2 increment
    load(32'h00AB, 32'h1234_5678, 32'd100);
    rd(8'h00, 32'd108, "R2 R3 timer ns");
    rd(8'h04, 32'h1234_5678, "R3 sec lo");
    rd(8'h08, 32'h0000_00AB, "R3 sec hi");

    // R4 R6 routing to four records
    load(32'h0, 32'h10, 32'd500);
    cap(1, 1, 1);
    cap(0, 1, 1);
    cap(1, 0, 1);
    cap(0, 0, 1);
    rd(8'h50, 32'd500, "R4 rec3 ns");
    rd(8'h54, 32'h10,  "R6 rec3 sec lo");
    rd(8'h58, 32'h0,   "R6 rec3 sec hi");
    rd(8'h30, 32'd508, "R4 rec1 ns");
    rd(8'h40, 32'd516, "R4 rec2 ns");
    rd(8'h20, 32'd524, "R4 rec0 ns");
    rd(8'h24, 32'h10,  "R6 rec0 sec lo");

    // R10 mask gating, R8 W1C
    #1; chk("R10 irq masked off", {31'd0, irq}, 32'd0);
    rd(8'h0C, 32'h0F, "R8 status all");
    wr(8'h10, 32'h4);
    #1; chk("R10 irq on", {31'd0, irq}, 32'd1);
    rd(8'h10, 32'h4, "R10 mask readback");
    wr(8'h0C, 32'h4);
    #1; chk("R10 irq after clear", {31'd0, irq}, 32'd0);
    rd(8'h0C, 32'h0B, "R8 w1c one bit");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h0B, "R8 write zero no effect");

    // R9 overrun on record 1
    load(32'h0, 32'h20, 32'd0);
    cap(0, 1, 1);
    rd(8'h0C, 32'h2B, "R9 overrun set");
    rd(8'h30, 32'd0,  "R9 rec1 overwritten ns");
    rd(8'h34, 32'h20, "R9 rec1 overwritten sec");
    wr(8'h0C, 32'h20);
    rd(8'h0C, 32'h0B, "R9 overrun w1c");

    // R5 unqualified strobe ignored
    wr(8'h10, 32'hF);
    wr(8'h0C, 32'hFF);
    load(32'h0, 32'h99, 32'd7);
    cap(0, 0, 0);
    #1; chk("R5 irq stays low", {31'd0, irq}, 32'd0);
    rd(8'h0C, 32'h0, "R5 status untouched");
    rd(8'h20, 32'd524, "R5 rec0 ns kept");
    rd(8'h24, 32'h10, "R5 rec0 sec kept");

    // R2 wrap with carry into upper seconds
    load(32'h0001, 32'hFFFF_FFFF, 32'd999_999_992);
    @(negedge clk);
    cap(1, 0, 1);
    #1; chk("R10 irq on capture", {31'd0, irq}, 32'd1);
    rd(8'h40, 32'd0, "R2 wrap ns");
    rd(8'h44, 32'h0, "R2 wrap sec lo");
    rd(8'h48, 32'h2, "R2 wrap sec hi");

    // R7 coherent read across an intervening capture
    rd(8'h40, 32'd0, "R7 ns latch");
    load(32'h0, 32'h55, 32'd1);
    cap(1, 0, 1);
    rd(8'h44, 32'h0, "R7 shadow lo held");
    rd(8'h48, 32'h2, "R7 shadow hi held");
    rd(8'h40, 32'd1, "R7 new ns");
    rd(8'h44, 32'h55, "R7 new sec lo");

    // R11 unmapped
    rd(8'h18, 32'h0, "R11 unmapped");
    rd(8'h2C, 32'h0, "R11 record aux");
    rd(8'h60, 32'h0, "R11 beyond records");

    @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard-leftover", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule